// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

An 8-bit general-purpose I/O port controlled through a small register bus. Software sets each pin's direction in a direction register and its level in an output-data register. It reads the pad levels from a read-only sampled-input register. For a pin set as an input, the output-data bit has a second job: it switches that pin's pull-up on or off.

Besides full-byte writes, the bus offers atomic single-bit set and clear commands. A command names one register and one bit position, and only that bit changes. No read-modify-write sequence is needed. Pad inputs pass through a two-flop synchronizer before they are visible in the input register.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and output-data registers read 0x00, every pin has pad_oe_o=0 and pad_pu_o=0, and the input register reads 0x00 until pads are sampled.
- R2: A bus write with wr_i=1 stores wdata_i into the direction register at address 1 or the output-data register at address 2, and reading the same address returns the stored byte from the next cycle on.
- R3: For a pin whose direction bit is 1, pad_oe_o is 1 and pad_out_o equals its output-data bit; pad_pu_o is 0.
- R4: For a pin whose direction bit is 0, pad_oe_o and pad_out_o are 0 and pad_pu_o equals its output-data bit.
- R5: Reading address 0 returns the pad_i value sampled two rising clock edges earlier.
- R6: A bus write to address 0 changes neither writable register.
- R7: bit_set_i=1 (bit_clr_i=0, wr_i=0) with addr_i 1 or 2 sets bit bit_sel_i of that register to 1 and leaves its other bits unchanged.
- R8: bit_clr_i=1 (bit_set_i=0, wr_i=0) with addr_i 1 or 2 clears bit bit_sel_i of that register and leaves its other bits unchanged.
- R9: When wr_i=1, any bit command in the same cycle is ignored. When bit_set_i and bit_clr_i are both 1, the command is ignored.
- R10: A bit command addressed to address 0 or 3 changes no register, and reading address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 2 | Register select: 0 input, 1 direction, 2 output data |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Byte write strobe |
| bit_set_i | input | 1 | Single-bit set command |
| bit_clr_i | input | 1 | Single-bit clear command |
| bit_sel_i | input | 3 | Bit position for set/clear |
| rdata_o | output | 8 | Read data for addr_i |
| pad_i | input | 8 | Pad input levels |
| pad_oe_o | output | 8 | Per-pin output enable |
| pad_out_o | output | 8 | Per-pin driven level |
| pad_pu_o | output | 8 | Per-pin pull-up enable |

## Verification
Assertions check on every cycle that the input register follows the pad two edges late. They also check that a single-bit command moves only the selected bit, that writes to the input address leave both registers alone, and that no pin ever has both drive and pull-up on. Only the bench scenarios show full-byte readback through the bus, the priority of byte writes over bit commands, the ignored set-plus-clear case, and the exact pad pattern produced by each mix of direction and data.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_PIN = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_DIR = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_OUT = 2'd2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
    // R5
    sync_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd2) |-> (q_o == $past(d_i, 2)));
  end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
  import gpio_port_pkg::*;
#(
  parameter int W     = 8,
  localparam int SEL_W = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              wr_i,
  input  logic              bit_set_i,
  input  logic              bit_clr_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      data_o
);
  logic [W-1:0] dir_q, data_q, dir_d, data_d, mask;
  logic         bit_ok;

  assign mask   = W'(1) << bit_sel_i;
  assign bit_ok = !wr_i && (bit_set_i ^ bit_clr_i);

  function automatic logic [W-1:0] next_val(input logic [W-1:0] cur,
                                             input logic hit);
    if (wr_i && hit) return wdata_i;
    if (bit_ok && hit) return bit_set_i ? (cur | mask) : (cur & ~mask);
    return cur;
  endfunction

  always_comb begin
    dir_d  = next_val(dir_q,  addr_i == ADDR_DIR);
    data_d = next_val(data_q, addr_i == ADDR_OUT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else begin
      dir_q  <= dir_d;
      data_q <= data_d;
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;

  // R6
  pin_addr_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_PIN) |=> ($stable(dir_q) && $stable(data_q)));
  // R7
  bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && bit_set_i && !bit_clr_i && addr_i == ADDR_OUT) |=>
      ((data_q & mask_q) == mask_q) && ((data_q & ~mask_q) == ($past(data_q) & ~mask_q)));
  // R8
  bit_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && bit_clr_i && !bit_set_i && addr_i == ADDR_DIR) |=>
      ((dir_q & mask_q) == '0) && ((dir_q & ~mask_q) == ($past(dir_q) & ~mask_q)));

  logic [W-1:0] mask_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else mask_q <= mask;
  end
endmodule

// File: rtl/gpio_pin_mode.sv
module gpio_pin_mode #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pu_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    always_comb begin
      oe_o[i]  = dir_i[i];
      out_o[i] = dir_i[i] & data_i[i];
      pu_o[i]  = ~dir_i[i] & data_i[i];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              wr_i,
  input  logic              bit_set_i,
  input  logic              bit_clr_i,
  input  logic [SEL_W-1:0]  bit_sel_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pad_i,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      pad_out_o,
  output logic [W-1:0]      pad_pu_o
);
  logic [W-1:0] dir, data, pin_sync;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(pin_sync)
  );

  gpio_reg_bank #(.W(W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i,
    .bit_set_i, .bit_clr_i, .bit_sel_i,
    .dir_o(dir), .data_o(data)
  );

  gpio_pin_mode #(.W(W)) u_mode (
    .dir_i(dir), .data_i(data),
    .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o)
  );

  always_comb begin
    unique case (addr_i)
      ADDR_PIN: rdata_o = pin_sync;
      ADDR_DIR: rdata_o = dir;
      ADDR_OUT: rdata_o = data;
      default:  rdata_o = '0;
    endcase
  end

  // R3
  drive_only_when_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_out_o & ~pad_oe_o) == '0);
  // R4
  no_pull_on_output_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_pu_o & pad_oe_o) == '0);
endmodule

// File: tb/gpio_port_tb_top.sv
`timescale 1ns/1ps
module gpio_port_tb_top;
  logic       clk_i = 0, rst_ni = 0;
  logic [1:0] addr_i = 0;
  logic [7:0] wdata_i = 0, pad_i = 0;
  logic       wr_i = 0, bit_set_i = 0, bit_clr_i = 0;
  logic [2:0] bit_sel_i = 0;
  logic [7:0] rdata_o, pad_oe_o, pad_out_o, pad_pu_o;
  int checks = 0, fails = 0;

  always #5 clk_i = ~clk_i;

  gpio_port dut_i (.*);

  typedef struct packed {
    logic [1:0] kind;  // 0 write, 1 set, 2 clear, 3 set+clear
    logic [1:0] addr;
    logic [7:0] val;
    logic [2:0] sel;
    logic [7:0] exp_dir;
    logic [7:0] exp_data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 2'd1, 8'hF0, 3'd0, 8'hF0, 8'h00},  // R2
    '{2'd0, 2'd2, 8'h3C, 3'd0, 8'hF0, 8'h3C},  // R2
    '{2'd1, 2'd1, 8'h00, 3'd0, 8'hF1, 8'h3C},  // R7
    '{2'd2, 2'd2, 8'h00, 3'd2, 8'hF1, 8'h38},  // R8
    '{2'd1, 2'd2, 8'h00, 3'd7, 8'hF1, 8'hB8},  // R7
    '{2'd2, 2'd1, 8'h00, 3'd7, 8'h71, 8'hB8},  // R8
    '{2'd3, 2'd1, 8'h00, 3'd1, 8'h71, 8'hB8},  // R9
    '{2'd0, 2'd0, 8'hFF, 3'd0, 8'h71, 8'hB8},  // R6
    '{2'd1, 2'd0, 8'h00, 3'd3, 8'h71, 8'hB8},  // R10
    '{2'd2, 2'd2, 8'h00, 3'd3, 8'h71, 8'hB0},  // R8
    '{2'd0, 2'd2, 8'hA5, 3'd0, 8'h71, 8'hA5}   // R2
  };

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] kind, logic [1:0] a, logic [7:0] v, logic [2:0] s, logic w_extra);
    @(negedge clk_i);
    addr_i = a; wdata_i = v; bit_sel_i = s;
    wr_i = (kind == 2'd0) || w_extra;
    bit_set_i = (kind == 2'd1) || (kind == 2'd3);
    bit_clr_i = (kind == 2'd2) || (kind == 2'd3);
    @(negedge clk_i);
    wr_i = 0; bit_set_i = 0; bit_clr_i = 0;
  endtask

  task automatic read_chk(string req, logic [1:0] a, logic [7:0] exp);
    addr_i = a; #1;
    chk(req, rdata_o, exp);
  endtask

  task automatic pads_chk(logic [7:0] d, logic [7:0] q);
    chk("R3 oe", pad_oe_o, d);
    chk("R3 out", pad_out_o, d & q);
    chk("R4 pu", pad_pu_o, ~d & q);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    read_chk("R1 dir", 2'd1, 8'h00);
    read_chk("R1 data", 2'd2, 8'h00);
    read_chk("R1 pin", 2'd0, 8'h00);
    chk("R1 oe", pad_oe_o, 8'h00);
    chk("R1 pu", pad_pu_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].kind, VECS[i].addr, VECS[i].val, VECS[i].sel, 1'b0);
      read_chk("R2/R6-R10 dir", 2'd1, VECS[i].exp_dir);
      read_chk("R2/R6-R10 data", 2'd2, VECS[i].exp_data);
      pads_chk(VECS[i].exp_dir, VECS[i].exp_data);
    end

    // R9 byte write wins over bit command
    apply(2'd1, 2'd1, 8'h0F, 3'd7, 1'b1);
    read_chk("R9 write priority", 2'd1, 8'h0F);
    pads_chk(8'h0F, 8'hA5);

    // R10 address 3 reads zero, bit command there ignored
    apply(2'd2, 2'd3, 8'h00, 3'd0, 1'b0);
    read_chk("R10 addr3", 2'd3, 8'h00);
    read_chk("R10 dir kept", 2'd1, 8'h0F);
    read_chk("R10 data kept", 2'd2, 8'hA5);

    // R5 two-edge synchronizer latency
    @(negedge clk_i);
    pad_i = 8'h5A;
    @(negedge clk_i);
    read_chk("R5 one edge", 2'd0, 8'h00);
    @(negedge clk_i);
    read_chk("R5 two edges", 2'd0, 8'h5A);
    pad_i = 8'hC3;
    repeat (2) @(negedge clk_i);
    read_chk("R5 second pattern", 2'd0, 8'hC3);

    // R1 reset mid-run
    rst_ni = 0; #1;
    read_chk("R1 dir after reset", 2'd1, 8'h00);
    chk("R1 pu after reset", pad_pu_o, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule